// File: doc/BRIEF.md
# Presence-Bitmap Directory Coherence Controller

This block is the home-node directory for a small group of memory blocks shared by several caches over a message network. For every block it stores a coherence state (Uncached, Shared or Exclusive), a presence bitmap with one bit per cache, and the block's memory value. Caches send it read misses, write misses, writes to a block they already share, write-backs, invalidate acknowledgements and fetched data. The controller answers with data replies, invalidates and fetch requests. Each message is addressed with a destination bitmap that names only caches holding the block. No message goes to every cache.

The controller accepts one message per cycle and emits at most one message per cycle. A transaction that must wait for other caches occupies a single pending slot. The wait is either for invalidate acknowledgements or for an owner's data. While the slot is occupied, every new request is refused with a retry message. The requesting cache is expected to send that request again later.

Top module: `dir_ctrl`

## Requirements
- R1: After reset every block is Uncached with an empty presence bitmap, block b holds the value b (truncated to the data width), and no message is emitted.
- R2: Input kinds are coded as 0 read miss, 1 write miss, 2 write to shared, 3 write-back, 4 invalidate acknowledge, 5 fetched data. Output kinds are coded as 0 data-shared, 1 data-exclusive, 2 invalidate, 3 fetch, 4 fetch-and-invalidate, 5 retry. Bit i of `out_dst` addresses cache i. Any message caused by an accepted input appears in the cycle after that input.
- R3: A read miss to an Uncached or Shared block replies data-shared with the memory value to the requester only, sets the requester's presence bit and leaves the block Shared.
- R4: A read miss to an Exclusive block sends a fetch to the owner alone. The owner's fetched data is written to memory and returned as data-shared to the reader. The block becomes Shared with both bits set.
- R5: A write request to a Shared block with other sharers sends one invalidate whose bitmap names exactly those other sharers. After the last matching acknowledgement it replies data-exclusive with the memory value to the writer. The writer then becomes the only holder and the block becomes Exclusive.
- R6: A write request to an Uncached block, or to a Shared block held by the requester alone, replies data-exclusive at once.
- R7: A write request to a block that is Exclusive in another cache sends fetch-and-invalidate to that owner. The fetched data goes to memory and to the writer as data-exclusive, and the writer becomes the sole owner.
- R8: A write-back from the owner of an Exclusive block updates memory and makes the block Uncached. A write-back from any other cache has no effect.
- R9: While a transaction is pending, every read or write request is answered with retry to its sender and changes no state. An acknowledgement or fetched-data message that does not match the pending transaction is ignored.
- R10: An Exclusive block has exactly one presence bit set and an Uncached block has none. Every message other than invalidate names exactly one cache, and an invalidate names only caches that held the block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming message present this cycle |
| in_kind | input | 3 | Incoming message kind |
| in_src | input | $clog2(NCACHE) | Sending cache index |
| in_blk | input | $clog2(NBLK) | Block index |
| in_data | input | DW | Data carried by write-back or fetched data |
| out_valid | output | 1 | Outgoing message present |
| out_kind | output | 3 | Outgoing message kind |
| out_dst | output | NCACHE | Destination bitmap |
| out_blk | output | $clog2(NBLK) | Block the message concerns |
| out_data | output | DW | Block data for data replies |

## Verification
The controller registers all of its outputs. The message caused by an input therefore becomes visible one clock edge after that input is sampled. For multi-step transactions, the reply comes one edge after the final acknowledgement or fetched-data message, not one edge after the original request. Each stimulus the driver applies queues the message it predicts, or the absence of any message, and stamps it with the cycle number at which it is due. The monitor samples the outputs on the falling edge. It compares only entries whose due cycle has arrived, and it counts any message that appears with no entry due as a miscompare.

// File: rtl/dir_ctrl.sv
module dir_ctrl #(
  parameter int NCACHE = 4,
  parameter int NBLK   = 8,
  parameter int DW     = 8,
  localparam int SW = $clog2(NCACHE),
  localparam int BW = $clog2(NBLK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        in_kind,
  input  logic [SW-1:0]     in_src,
  input  logic [BW-1:0]     in_blk,
  input  logic [DW-1:0]     in_data,
  output logic              out_valid,
  output logic [2:0]        out_kind,
  output logic [NCACHE-1:0] out_dst,
  output logic [BW-1:0]     out_blk,
  output logic [DW-1:0]     out_data
);
  localparam logic [2:0] I_RD = 3'd0, I_WRM = 3'd1, I_WRS = 3'd2,
                         I_WB = 3'd3, I_ACK = 3'd4, I_FD  = 3'd5;
  localparam logic [2:0] O_DSH = 3'd0, O_DEX = 3'd1, O_INV = 3'd2,
                         O_FET = 3'd3, O_FIN = 3'd4, O_RTY = 3'd5;
  localparam logic [1:0] K_INV = 2'd0, K_FRD = 2'd1, K_FWR = 2'd2;

  typedef enum logic [1:0] {UNC = 2'd0, SHR = 2'd1, EXC = 2'd2} dstate_t;

  dstate_t           st   [NBLK];
  logic [NCACHE-1:0] pres [NBLK];
  logic [DW-1:0]     mem  [NBLK];

  logic              busy;
  logic [1:0]        p_kind;
  logic [BW-1:0]     p_blk;
  logic [NCACHE-1:0] p_req;
  logic [NCACHE-1:0] p_wait;

  wire [NCACHE-1:0] sbit     = NCACHE'(1) << in_src;
  wire dstate_t     cur_st   = st[in_blk];
  wire [NCACHE-1:0] cur_pres = pres[in_blk];
  wire [NCACHE-1:0] others   = cur_pres & ~sbit;
  wire [NCACHE-1:0] wait_nx  = p_wait & ~sbit;
  wire              hit_p    = busy && (in_blk == p_blk);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NBLK; i++) begin
        st[i]   <= UNC;
        pres[i] <= '0;
        mem[i]  <= DW'(i);
      end
      busy      <= 1'b0;
      p_kind    <= K_INV;
      p_blk     <= '0;
      p_req     <= '0;
      p_wait    <= '0;
      out_valid <= 1'b0;
      out_kind  <= O_DSH;
      out_dst   <= '0;
      out_blk   <= '0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_blk   <= in_blk;
      if (in_valid) begin
        case (in_kind)
          I_RD: begin
            out_valid <= 1'b1;
            if (busy) begin
              out_kind <= O_RTY;
              out_dst  <= sbit;
            end else if (cur_st == EXC && cur_pres != sbit) begin
              out_kind <= O_FET;
              out_dst  <= cur_pres;
              busy     <= 1'b1;
              p_kind   <= K_FRD;
              p_blk    <= in_blk;
              p_req    <= sbit;
              p_wait   <= cur_pres;
            end else begin
              out_kind <= O_DSH;
              out_dst  <= sbit;
              out_data <= mem[in_blk];
              pres[in_blk] <= cur_pres | sbit;
              if (cur_st != EXC) st[in_blk] <= SHR;
            end
          end
          I_WRM, I_WRS: begin
            out_valid <= 1'b1;
            if (busy) begin
              out_kind <= O_RTY;
              out_dst  <= sbit;
            end else if (cur_st == EXC && cur_pres != sbit) begin
              out_kind <= O_FIN;
              out_dst  <= cur_pres;
              busy     <= 1'b1;
              p_kind   <= K_FWR;
              p_blk    <= in_blk;
              p_req    <= sbit;
              p_wait   <= cur_pres;
            end else if (cur_st == SHR && others != '0) begin
              out_kind <= O_INV;
              out_dst  <= others;
              busy     <= 1'b1;
              p_kind   <= K_INV;
              p_blk    <= in_blk;
              p_req    <= sbit;
              p_wait   <= others;
            end else begin
              out_kind <= O_DEX;
              out_dst  <= sbit;
              out_data <= mem[in_blk];
              pres[in_blk] <= sbit;
              st[in_blk]   <= EXC;
            end
          end
          I_WB: begin
            if (cur_st == EXC && cur_pres == sbit) begin
              mem[in_blk]  <= in_data;
              pres[in_blk] <= '0;
              st[in_blk]   <= UNC;
            end
          end
          I_ACK: begin
            if (hit_p && p_kind == K_INV && (p_wait & sbit) != '0) begin
              p_wait <= wait_nx;
              if (wait_nx == '0) begin
                busy        <= 1'b0;
                out_valid   <= 1'b1;
                out_kind    <= O_DEX;
                out_dst     <= p_req;
                out_data    <= mem[p_blk];
                pres[p_blk] <= p_req;
                st[p_blk]   <= EXC;
              end
            end
          end
          I_FD: begin
            if (hit_p && p_kind != K_INV && p_wait == sbit) begin
              busy       <= 1'b0;
              mem[p_blk] <= in_data;
              out_valid  <= 1'b1;
              out_dst    <= p_req;
              out_data   <= in_data;
              if (p_kind == K_FRD) begin
                out_kind    <= O_DSH;
                pres[p_blk] <= p_wait | p_req;
                st[p_blk]   <= SHR;
              end else begin
                out_kind    <= O_DEX;
                pres[p_blk] <= p_req;
                st[p_blk]   <= EXC;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module dir_ctrl_chk #(
  parameter int NCACHE = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [1:0]        cur_st,
  input logic [NCACHE-1:0] cur_pres,
  input logic              busy,
  input logic              out_valid,
  input logic [2:0]        out_kind,
  input logic [NCACHE-1:0] out_dst
);
  assert_excl_one_owner_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && cur_st == 2'd2 |-> $onehot(cur_pres));

  assert_uncached_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && cur_st == 2'd0 |-> cur_pres == '0);

  assert_single_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_kind != 3'd2 |-> $onehot(out_dst));

  assert_inv_to_holders_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_kind == 3'd2 |-> out_dst != '0 && (out_dst & ~$past(cur_pres)) == '0);

  assert_retry_only_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_kind == 3'd5 |-> $past(busy));

  assert_wait_holds_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_kind == 3'd2 || out_kind == 3'd3 || out_kind == 3'd4) |-> busy);

  assert_quiet_after_reset_R1: assert property (@(posedge clk)
    !$past(rst_n) |-> !out_valid);
endmodule

bind dir_ctrl dir_ctrl_chk #(.NCACHE(NCACHE)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cur_st(cur_st),
  .cur_pres(cur_pres), .busy(busy), .out_valid(out_valid),
  .out_kind(out_kind), .out_dst(out_dst)
);

// File: tb/dir_ctrl_tb.sv
module dir_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [2:0] in_kind = '0;
  logic [1:0] in_src = '0;
  logic [2:0] in_blk = '0;
  logic [7:0] in_data = '0;
  logic       out_valid;
  logic [2:0] out_kind;
  logic [3:0] out_dst;
  logic [2:0] out_blk;
  logic [7:0] out_data;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit live = 1'b0;

  typedef struct {
    int       due;
    bit       v;
    bit       chkd;
    logic [2:0] k;
    logic [3:0] dst;
    logic [7:0] d;
    string    tag;
  } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dir_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind),
    .in_src(in_src), .in_blk(in_blk), .in_data(in_data),
    .out_valid(out_valid), .out_kind(out_kind), .out_dst(out_dst),
    .out_blk(out_blk), .out_data(out_data)
  );

  always @(negedge clk) begin
    if (live) begin
      if (q.size() > 0 && q[0].due <= cyc) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (!e.v) begin
          if (out_valid) begin
            fails++;
            $display("FAIL %s: message kind %0d dst %b, expected none", e.tag, out_kind, out_dst);
          end
        end else if (!out_valid || out_kind !== e.k || out_dst !== e.dst ||
                     (e.chkd && out_data !== e.d)) begin
          fails++;
          $display("FAIL %s: got v%0d kind %0d dst %b data %h, expected kind %0d dst %b data %h",
                   e.tag, out_valid, out_kind, out_dst, out_data, e.k, e.dst, e.d);
        end
      end else if (out_valid) begin
        checks++;
        fails++;
        $display("FAIL R2: unexpected kind %0d dst %b, expected none", out_kind, out_dst);
      end
    end
  end

  task automatic send(input logic [2:0] k, input logic [1:0] s, input logic [2:0] b,
                      input logic [7:0] d, input bit ev, input logic [2:0] ek,
                      input logic [3:0] edst, input bit chkd, input logic [7:0] ed,
                      input string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; in_kind = k; in_src = s; in_blk = b; in_data = d;
    e.due = cyc + 1; e.v = ev; e.chkd = chkd; e.k = ek; e.dst = edst; e.d = ed; e.tag = tag;
    q.push_back(e);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1: out_valid %b, expected 0", out_valid);
    end
    live = 1'b1;
    // R1 R3: reads of an uncached block return reset value; sharers accumulate
    send(0, 0, 1, 0, 1, 0, 4'b0001, 1, 8'h01, "R3 rd c0 U");
    send(0, 2, 1, 0, 1, 0, 4'b0100, 1, 8'h01, "R3 rd c2 S");
    send(0, 3, 1, 0, 1, 0, 4'b1000, 1, 8'h01, "R3 rd c3 S");
    // R5: write to shared invalidates the other sharers only
    send(2, 0, 1, 0, 1, 2, 4'b1100, 0, 0, "R5 inv others");
    send(0, 1, 1, 0, 1, 5, 4'b0010, 0, 0, "R9 retry while waiting");
    send(4, 2, 1, 0, 0, 0, 0, 0, 0, "R5 first ack silent");
    send(4, 2, 1, 0, 0, 0, 0, 0, 0, "R9 duplicate ack ignored");
    send(4, 3, 1, 0, 1, 1, 4'b0001, 1, 8'h01, "R5 last ack grants");
    // R4: read of exclusive block fetches from owner
    send(0, 1, 1, 0, 1, 3, 4'b0001, 0, 0, "R4 fetch owner");
    send(5, 2, 1, 8'h99, 0, 0, 0, 0, 0, "R9 fetch data wrong src ignored");
    send(5, 0, 1, 8'h5A, 1, 0, 4'b0010, 1, 8'h5A, "R4 reply shared");
    send(1, 2, 1, 0, 1, 2, 4'b0011, 0, 0, "R4 both holders invalidated");
    send(4, 0, 1, 0, 0, 0, 0, 0, 0, "R5 ack c0");
    send(4, 1, 1, 0, 1, 1, 4'b0100, 1, 8'h5A, "R5 ack c1 grants");
    // R8: owner write-back then read sees new value
    send(3, 2, 1, 8'h77, 0, 0, 0, 0, 0, "R8 owner wb");
    send(0, 3, 1, 0, 1, 0, 4'b1000, 1, 8'h77, "R8 memory updated");
    // R6 R7: write miss to uncached, then to exclusive elsewhere
    send(1, 1, 2, 0, 1, 1, 4'b0010, 1, 8'h02, "R6 wr miss U");
    send(1, 3, 2, 0, 1, 4, 4'b0010, 0, 0, "R7 fetch-inv owner");
    send(5, 1, 2, 8'h33, 1, 1, 4'b1000, 1, 8'h33, "R7 new owner data");
    send(3, 0, 2, 8'hEE, 0, 0, 0, 0, 0, "R8 non-owner wb");
    send(0, 0, 2, 0, 1, 3, 4'b1000, 0, 0, "R8 owner unchanged");
    send(5, 3, 2, 8'h44, 1, 0, 4'b0001, 1, 8'h44, "R4 reply from c3");
    // R6: sole sharer upgrades at once
    send(0, 2, 3, 0, 1, 0, 4'b0100, 1, 8'h03, "R3 rd blk3");
    send(2, 2, 3, 0, 1, 1, 4'b0100, 1, 8'h03, "R6 sole sharer upgrade");
    send(4, 1, 3, 0, 0, 0, 0, 0, 0, "R9 stray ack idle");
    // R9: pending slot refuses other blocks too, state untouched
    send(0, 0, 5, 0, 1, 0, 4'b0001, 1, 8'h05, "R3 rd blk5 c0");
    send(0, 1, 5, 0, 1, 0, 4'b0010, 1, 8'h05, "R3 rd blk5 c1");
    send(1, 0, 5, 0, 1, 2, 4'b0010, 0, 0, "R5 inv c1");
    send(1, 3, 6, 0, 1, 5, 4'b1000, 0, 0, "R9 other block retried");
    send(4, 1, 5, 0, 1, 1, 4'b0001, 1, 8'h05, "R5 grant blk5");
    send(0, 3, 6, 0, 1, 0, 4'b1000, 1, 8'h06, "R9 blk6 unchanged by retry");
    repeat (4) @(posedge clk);
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule